// File: doc/BRIEF.md
# Partitioned Berger Code Checker

This block decides whether a separable Berger-coded word is a legal codeword. The word has an information field of `INFO_W` bits and a check field of `CHK_W = clog2(INFO_W+1)` bits. The check field holds the bitwise complement of the binary count of ones in the information field.

The checker splits the information field into a low half and a high half. It counts the ones in each half with small counter cells of at most four inputs, then adds the two partial counts. Each regenerated count bit is paired with the matching received check bit, and a chain of two-rail cells reduces the pairs to one output pair `(z1, z0)`. That pair is complementary for a codeword and equal for anything else. Because of this encoding, every unidirectional corruption of the word is flagged.

A qualifier travels with each word. The `PIPE` parameter selects one of two variants: a registered result one clock after the input, or a purely combinational result.

Top module: `pbc_checker`

## Requirements
- R1: The check width is `clog2(INFO_W+1)`. A word is a codeword exactly when `in_check` equals the bitwise complement of the number of ones in `in_info`, taken in `CHK_W` bits. For example, with 16 information bits, an all-ones field pairs with check `5'b01111` and an all-zeros field pairs with `5'b11111`.
- R2: For a codeword, the output pair `{out_z1,out_z0}` is `01` or `10`.
- R3: For any word that is not a codeword, the output pair is `00` or `11`.
- R4: Take any codeword and flip any nonzero set of its bits, across both fields, all in the same direction (only 1 to 0, or only 0 to 1). The result must give an equal output pair.
- R5: With `PIPE=1`, the result for a word presented with `in_valid` high appears on the outputs one clock later, and `out_valid` equals `in_valid` delayed by one clock.
- R6: With `PIPE=1`, while `in_valid` is low the output pair keeps the last reported result, whatever the data inputs do.
- R7: With `PIPE=1`, while `rst_n` is low, `out_valid` is 0 and the output pair is `00`.
- R8: With `PIPE=0`, the outputs follow the inputs in the same cycle: `out_valid` equals `in_valid`, and R2/R3 hold on the current word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies the word on the data inputs |
| in_info | input | INFO_W | Information field |
| in_check | input | CHK_W | Received check field |
| out_valid | output | 1 | Qualifies the output pair |
| out_z1 | output | 1 | Two-rail result, first rail |
| out_z0 | output | 1 | Two-rail result, second rail |

## Verification
The properties assume that `in_valid`, `in_info` and `in_check` are known (not X) at every clock edge after reset. They also assume that the data inputs are meaningful only while `in_valid` is high. The stimulus drives every input to a defined value from time zero, changing it on the falling edge only. The words it sends while the qualifier is low are deliberately random, so that the hold property is really exercised. Codewords are generated from the encoding rule in R1. Non-codewords are generated in two ways: by corrupting the check field, and by unidirectional masks limited to the bits that can actually move in the chosen direction.

// File: rtl/pbc_pkg.sv
// Package pbc_pkg: shared helpers for the partitioned Berger checker.
// Assumes block widths of 2 or more; the decomposition puts four-input
// cells first and covers any remainder with 2- or 3-input cells.
package pbc_pkg;

    // Number of counter cells used to cover a block of bw bits.
    function automatic int cell_count(input int bw);
        int n4;
        int r;
        n4 = bw / 4;
        r  = bw % 4;
        if (r == 0) return n4;
        if (r == 1) return n4 + 1;   // one 4-cell becomes a 3-cell plus a 2-cell
        return n4 + 1;
    endfunction

    // Input count of cell idx inside a block of bw bits.
    function automatic int cell_width(input int bw, input int idx);
        int n4;
        int r;
        n4 = bw / 4;
        r  = bw % 4;
        if (r == 0) return 4;
        if (r == 1) begin
            if (idx < n4 - 1) return 4;
            if (idx == n4 - 1) return 3;
            return 2;
        end
        if (idx < n4) return 4;
        return r;
    endfunction

    // Bit offset of cell idx inside its block.
    function automatic int cell_offset(input int bw, input int idx);
        int off;
        off = 0;
        for (int i = 0; i < idx; i++) off += cell_width(bw, i);
        return off;
    endfunction

endpackage

// File: rtl/ones_cell.sv
// ones_cell: counts the ones on N inputs (N = 2, 3 or 4) into a 3-bit value.
// Every gate in the cell has at most four inputs.
module ones_cell #(
    parameter int N = 4
) (
    input  logic [N-1:0] bits,
    output logic [2:0]   cnt
);

    generate
        if (N == 2) begin : g_two
            // Half adder.
            assign cnt = {1'b0, bits[1] & bits[0], bits[1] ^ bits[0]};
        end else if (N == 3) begin : g_three
            // Full adder: parity and majority.
            assign cnt = {1'b0,
                          (bits[0] & bits[1]) | (bits[0] & bits[2]) | (bits[1] & bits[2]),
                          bits[0] ^ bits[1] ^ bits[2]};
        end else if (N == 4) begin : g_four
            logic h_lo, c_lo, h_hi, c_hi, c_mid;
            // Two half adders on the input pairs, then merge the weight-two carries.
            always_comb begin
                h_lo  = bits[0] ^ bits[1];
                c_lo  = bits[0] & bits[1];
                h_hi  = bits[2] ^ bits[3];
                c_hi  = bits[2] & bits[3];
                c_mid = h_lo & h_hi;
                cnt   = {c_lo & c_hi, c_lo ^ c_hi ^ c_mid, h_lo ^ h_hi};
            end
        end else begin : g_other
            assign cnt = 3'($countones(bits));
        end
    endgenerate

endmodule

// File: rtl/block_counter.sv
// block_counter: ones count of one information block, built from small
// counter cells whose partial sums are added. Assumes BW >= 2.
module block_counter
    import pbc_pkg::*;
#(
    parameter int BW    = 8,
    localparam int OUT_W = $clog2(BW + 1)
) (
    input  logic [BW-1:0]    bits,
    output logic [OUT_W-1:0] count
);

    localparam int NC    = cell_count(BW);
    localparam int SUM_W = (OUT_W > 3) ? OUT_W : 3;

    logic [2:0]       part [NC];
    logic [SUM_W-1:0] acc;

    generate
        for (genvar g = 0; g < NC; g++) begin : g_cell
            localparam int W   = cell_width(BW, g);
            localparam int OFF = cell_offset(BW, g);
            ones_cell #(.N(W)) u_cell (
                .bits (bits[OFF +: W]),
                .cnt  (part[g])
            );
        end
    endgenerate

    // Adder chain over the partial cell counts.
    always_comb begin
        acc = '0;
        for (int i = 0; i < NC; i++) acc = acc + SUM_W'(part[i]);
    end

    assign count = acc[OUT_W-1:0];

endmodule

// File: rtl/tworail_tree.sv
// tworail_tree: reduces NP rail pairs (a[i], b[i]) to one pair.
// The result is complementary only when every input pair is complementary.
module tworail_tree #(
    parameter int NP = 4
) (
    input  logic [NP-1:0] a,
    input  logic [NP-1:0] b,
    output logic          z1,
    output logic          z0
);

    logic f [NP];
    logic g [NP];

    assign f[0] = a[0];
    assign g[0] = b[0];

    generate
        for (genvar i = 1; i < NP; i++) begin : g_stage
            // Classic two-pair two-rail cell.
            assign f[i] = (f[i-1] & a[i]) | (g[i-1] & b[i]);
            assign g[i] = (f[i-1] & b[i]) | (g[i-1] & a[i]);
        end
    endgenerate

    assign z1 = f[NP-1];
    assign z0 = g[NP-1];

endmodule

// File: rtl/pbc_checker.sv
// pbc_checker: Berger codeword checker with a two-rail result.
// The check field is the bitwise complement of the ones count of in_info.
// Assumes 4 <= INFO_W <= 32. PIPE=1 adds one result register.
module pbc_checker #(
    parameter int  INFO_W = 16,
    parameter bit  PIPE   = 1'b1,
    localparam int CHK_W  = $clog2(INFO_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INFO_W-1:0] in_info,
    input  logic [CHK_W-1:0]  in_check,
    output logic              out_valid,
    output logic              out_z1,
    output logic              out_z0
);

    localparam int LO_W   = INFO_W / 2;
    localparam int HI_W   = INFO_W - LO_W;
    localparam int LO_CW  = $clog2(LO_W + 1);
    localparam int HI_CW  = $clog2(HI_W + 1);

    logic [LO_CW-1:0] lo_cnt;
    logic [HI_CW-1:0] hi_cnt;
    logic [CHK_W-1:0] ones;
    logic             comb_z1;
    logic             comb_z0;

    block_counter #(.BW(LO_W)) u_lo (
        .bits  (in_info[LO_W-1:0]),
        .count (lo_cnt)
    );

    block_counter #(.BW(HI_W)) u_hi (
        .bits  (in_info[INFO_W-1:LO_W]),
        .count (hi_cnt)
    );

    // Sum of the two block counts.
    assign ones = CHK_W'(lo_cnt) + CHK_W'(hi_cnt);

    // A codeword pairs each count bit with its complement in the check field.
    tworail_tree #(.NP(CHK_W)) u_cmp (
        .a  (ones),
        .b  (in_check),
        .z1 (comb_z1),
        .z0 (comb_z0)
    );

    generate
        if (PIPE) begin : g_pipe
            logic       v_q;
            logic [1:0] z_q;
            // Output register: qualifier every cycle, result only on valid.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    z_q <= 2'b00;
                end else begin
                    v_q <= in_valid;
                    if (in_valid) z_q <= {comb_z1, comb_z0};
                end
            end
            assign out_valid = v_q;
            assign out_z1    = z_q[1];
            assign out_z0    = z_q[0];
        end else begin : g_comb
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst_n;
            assign out_valid = in_valid;
            assign out_z1    = comb_z1;
            assign out_z0    = comb_z0;
        end
    endgenerate

endmodule

// File: rtl/pbc_checker_sva.sv
// pbc_checker_sva: properties of pbc_checker at its ports.
// Assumes inputs are known at each clock edge after reset.
module pbc_checker_sva #(
    parameter int  INFO_W = 16,
    parameter bit  PIPE   = 1'b1,
    localparam int CHK_W  = $clog2(INFO_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [INFO_W-1:0] in_info,
    input logic [CHK_W-1:0]  in_check,
    input logic              out_valid,
    input logic              out_z1,
    input logic              out_z0
);

    // Encoding rule of R1, taken from the requirement.
    logic [CHK_W-1:0] want_chk;
    logic             is_cw;
    assign want_chk = ~CHK_W'($countones(in_info));
    assign is_cw    = (in_check == want_chk);

    generate
        if (PIPE) begin : g_pipe
            p_cw_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && is_cw |=> out_z1 != out_z0);
            p_noncw_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && !is_cw |=> out_z1 == out_z0);
            p_valid_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            p_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            p_pair_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable({out_z1, out_z0}));
        end else begin : g_comb
            p_valid_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == in_valid);
            p_comb_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> ((out_z1 != out_z0) == is_cw));
        end
    endgenerate

endmodule

bind pbc_checker pbc_checker_sva #(.INFO_W(INFO_W), .PIPE(PIPE)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_info   (in_info),
    .in_check  (in_check),
    .out_valid (out_valid),
    .out_z1    (out_z1),
    .out_z0    (out_z0)
);

// File: tb/pbc_checker_bench.sv
// Bench: registered 16-bit instance plus combinational 13-bit instance.
module pbc_checker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] info1 = '0;
    logic [4:0]  chk1 = '0;
    logic [12:0] info2 = '0;
    logic [3:0]  chk2 = '0;
    logic        ov1, z1a, z0a;
    logic        ov2, z1b, z0b;
    logic [1:0]  last_pair;
    int          tests = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    pbc_checker #(.INFO_W(16), .PIPE(1'b1)) u_pbc_checker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_info(info1),
        .in_check(chk1), .out_valid(ov1), .out_z1(z1a), .out_z0(z0a));

    pbc_checker #(.INFO_W(13), .PIPE(1'b0)) u_pbc_checker_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_info(info2),
        .in_check(chk2), .out_valid(ov2), .out_z1(z1b), .out_z0(z0b));

    // R1 encoding for each width.
    function automatic logic [4:0] enc16(input logic [15:0] d);
        return ~5'($countones(d));
    endfunction
    function automatic logic [3:0] enc13(input logic [12:0] d);
        return ~4'($countones(d));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One step: drive at the falling edge, check the combinational
    // instance after settling, then the registered instance one clock on.
    task automatic step(input logic v, input logic [15:0] i1, input logic [4:0] c1,
                        input logic [12:0] i2, input logic [3:0] c2, input string req1);
        in_valid = v; info1 = i1; chk1 = c1; info2 = i2; chk2 = c2;
        #1;
        chk("R8 valid", 32'(ov2), 32'(v));
        if (v) chk("R8 pair", 32'(z1b ^ z0b), 32'(c2 == enc13(i2)));
        @(negedge clk);
        chk("R5 valid", 32'(ov1), 32'(v));
        if (v) begin
            chk(req1, 32'(z1a ^ z0a), 32'(c1 == enc16(i1)));
            last_pair = {z1a, z0a};
        end else begin
            chk("R6 hold", 32'({z1a, z0a}), 32'(last_pair));
        end
    endtask

    function automatic logic [12:0] r13();
        return 13'($urandom);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R7 reset valid", 32'(ov1), 32'd0);
        chk("R7 reset pair", 32'({z1a, z0a}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 after reset idle", 32'(ov1), 32'd0);

        // Directed corners.
        step(1, 16'h0000, 5'b11111, 13'h0000, 4'b1111, "R1 zero info");
        chk("R2 zero info pair", 32'(z1a ^ z0a), 32'd1);
        step(1, 16'hFFFF, 5'b01111, 13'h1FFF, 4'b0010, "R1 full info");
        chk("R2 full info pair", 32'(z1a ^ z0a), 32'd1);
        step(1, 16'h0000, 5'b00000, 13'h0000, 4'b0000, "R3 zero check");
        chk("R3 zero check pair", 32'(z1a ^ z0a), 32'd0);
        step(1, 16'hFFFF, 5'b11111, 13'h1FFF, 4'b1111, "R3 full check");
        last_pair = {z1a, z0a};
        step(0, 16'h1234, 5'b10101, 13'h0ABC, 4'b0101, "R6 idle");
        step(0, 16'hFFFF, 5'b01111, 13'h1FFF, 4'b0010, "R6 idle codeword");

        // Random codewords, random non-codewords, idle gaps.
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            logic [12:0] b;
            logic [4:0]  e1;
            logic [3:0]  e2;
            logic        bad;
            a = 16'($urandom);
            b = r13();
            bad = $urandom % 2;
            e1 = bad ? (enc16(a) ^ (5'($urandom % 31) + 5'd1)) : enc16(a);
            e2 = ($urandom % 2) ? (enc13(b) ^ (4'($urandom % 15) + 4'd1)) : enc13(b);
            if ($urandom % 5 == 0)
                step(0, a, e1, b, e2, "R6 gap");
            else
                step(1, a, e1, b, e2, bad ? "R3 random" : "R2 random");
        end

        // Unidirectional corruption over the whole 21-bit word.
        for (int n = 0; n < 300; n++) begin
            logic [20:0] w;
            logic [20:0] m;
            logic [15:0] a;
            logic        up;
            a  = 16'($urandom);
            w  = {a, enc16(a)};
            m  = 21'($urandom) & 21'($urandom);
            up = $urandom % 2;
            if (up) begin
                m = m & ~w;
                if (m == 0) m = ~w & (w + 21'd1);
                w = w | m;
            end else begin
                m = m & w;
                if (m == 0) m = w & (~w + 21'd1);
                w = w & ~m;
            end
            step(1, w[20:5], w[4:0], r13(), 4'($urandom), "R4 unidirectional");
            chk("R4 error flagged", 32'(z1a ^ z0a), 32'd0);
        end

        step(0, 16'h0F0F, 5'b00001, 13'h0001, 4'b0001, "R5 drain");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        #(8 * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule